// File: doc/BRIEF.md
# TDM Daisy-Chain Audio Output Serializer

This block places one stereo sample pair on a serial line shared by several identical devices wired in a chain. Each frame lasts one output sample period and is split into sub-frames of 64 bit periods. The device drives its own sub-frame first. The left sample occupies a 32-bit slot, and the right sample follows in a second 32-bit slot. Each sample is sent most significant bit first and left justified in its slot. For the rest of the frame the device forwards the serial data arriving on its chain input, delayed by exactly one sub-frame. This way the sub-frames of the upstream devices appear behind its own. With `N_DEV` devices the frame is `64*N_DEV` bit periods long.

The clock `clk` is the bit clock. State advances on its rising edge, and the serial output changes on its falling edge, so the next device in the chain can capture the data on its own rising edge. In slave mode a rising edge on the frame clock input starts a frame. In master mode the block counts frames on its own and drives a frame pulse that is high for 32 bit periods.

A new sample pair and the word-length code are taken at each frame start. If no new pair was presented, the previous pair is sent again.

Top module: `tdm_chain_tx`

## Requirements
- R1: While reset is asserted and after its release, `sdo_o` and `fs_o` are 0. In slave mode, with no frame clock edge and the chain input at 0, `sdo_o` stays 0.
- R2: Bit positions are counted from the frame start. Positions 0 to 31 carry the left sample and positions 32 to 63 carry the right sample. Each sample is sent MSB first, starting at the first position of its slot.
- R3: The word-length code `wl_i` selects the number of sample bits sent per slot: 00 gives 24 bits, 01 gives 20, 10 gives 18 and 11 gives 16. These are the top bits of the 24-bit sample. All later positions in the slot are 0.
- R4: The chain input value captured at the rising edge ending frame position j appears on `sdo_o` at position j+64, for every position from 64 to 64*N_DEV-1.
- R5: In slave mode, a frame starts at the rising bit-clock edge on which `fs_i` is first seen high. Position 0 is driven at the falling edge that follows. `sdo_o` changes only on falling edges. After the last position the counter holds until the next frame clock edge.
- R6: In master mode, frames repeat every 64*N_DEV bit periods. `fs_o` goes high together with position 0 and stays high for 32 bit periods. `fs_i` is ignored.
- R7: A sample pair offered with `smp_vld_i` is sent in the next frame. A frame that starts without a new pair sends the last pair again.
- R8: The word-length code is sampled at the frame start. A change during a frame takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| master_i | input | 1 | 1 = block generates frames, 0 = frames follow `fs_i` |
| fs_i | input | 1 | Frame clock input used in slave mode |
| fs_o | output | 1 | Frame pulse driven in master mode, 0 in slave mode |
| smp_l_i | input | 24 | Left sample, two's complement |
| smp_r_i | input | 24 | Right sample, two's complement |
| smp_vld_i | input | 1 | One-cycle strobe that offers a new sample pair |
| wl_i | input | 2 | Word-length code (see R3) |
| chain_i | input | 1 | Serial data from the upstream device, 0 when unused |
| sdo_o | output | 1 | Serial TDM output |

## Verification
The bench builds the block with `N_DEV = 3`, which gives a 192-bit frame. The bit counter's range is then not a power of two, so its wrap point in master mode and its hold point in slave mode are not reached by a natural overflow. This length also leaves two forwarded sub-frames behind the block's own. A single captured frame therefore checks the sub-frame boundary at position 64, the forwarding delay across 128 positions, and the return to zero once a word shorter than its slot ends. All four word lengths are covered, together with repeated pairs and a mid-frame word-length change.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int SMP_BITS  = 24;
    localparam int SLOT_BITS = 32;
    localparam int SUB_BITS  = 2 * SLOT_BITS;
    localparam int SLOT_W    = $clog2(SLOT_BITS);
    localparam int OFF_W     = $clog2(SUB_BITS);

    typedef logic [SMP_BITS-1:0] smp_t;

    typedef struct packed {
        smp_t left;
        smp_t right;
    } pair_t;

    typedef enum logic [1:0] {
        WL_24 = 2'b00,
        WL_20 = 2'b01,
        WL_18 = 2'b10,
        WL_16 = 2'b11
    } wl_e;

    // Number of sample bits carried in a slot for a word-length code.
    function automatic logic [SLOT_W-1:0] wl_len(input wl_e code);
        logic [SLOT_W-1:0] n;
        case (code)
            WL_24:   n = SLOT_W'(24);
            WL_20:   n = SLOT_W'(20);
            WL_18:   n = SLOT_W'(18);
            default: n = SLOT_W'(16);
        endcase
        return n;
    endfunction

    // Bit of a left-justified, MSB-first sample at slot offset off.
    function automatic logic slot_bit(input smp_t s,
                                      input logic [SLOT_W-1:0] off,
                                      input logic [SLOT_W-1:0] len);
        logic r;
        r = 1'b0;
        for (int i = 0; i < SMP_BITS; i++) begin
            if ((off < len) && (int'(off) == SMP_BITS - 1 - i)) begin
                r = s[i];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_tx_pkg::*;
#(
    parameter  int FRAME_BITS = 512,
    localparam int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             master_i,
    input  logic             fs_i,
    output logic             start_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fs_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    logic             fs_q;
    logic [CNT_W-1:0] cnt_q;

    // Master: wrap after the last position. Slave: rising frame clock edge.
    assign start_o = master_i ? (cnt_q == LAST) : (fs_i & ~fs_q);
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q  <= 1'b0;
            cnt_q <= LAST;
        end else begin
            fs_q <= fs_i;
            if (start_o) begin
                cnt_q <= '0;
            end else if (cnt_q != LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Frame pulse launched on the falling edge, aligned with position 0.
    always_ff @(negedge clk) begin
        if (rst) begin
            fs_o <= 1'b0;
        end else begin
            fs_o <= master_i && (int'(cnt_q) < SLOT_BITS);
        end
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start_o |=> cnt_q == '0);                                   // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!master_i && !start_o && cnt_q == LAST) |=> cnt_q == LAST); // R5

endmodule

// File: rtl/tdm_slot_mux.sv
module tdm_slot_mux
    import tdm_tx_pkg::*;
(
    input  pair_t            pair_i,
    input  wl_e              wl_i,
    input  logic [OFF_W-1:0] pos_i,
    output logic             bit_o
);

    smp_t              smp;
    logic [SLOT_W-1:0] len;

    assign len   = wl_len(wl_i);
    assign smp   = pos_i[SLOT_W] ? pair_i.right : pair_i.left;
    assign bit_o = slot_bit(smp, pos_i[SLOT_W-1:0], len);

endmodule

// File: rtl/tdm_chain_delay.sv
module tdm_chain_delay #(
    parameter int DEPTH = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic din_i,
    output logic dout_o
);

    logic [DEPTH-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= {sr_q[DEPTH-2:0], din_i};
        end
    end

    assign dout_o = sr_q[DEPTH-1];

endmodule

// File: rtl/tdm_chain_tx.sv
module tdm_chain_tx
    import tdm_tx_pkg::*;
#(
    parameter  int N_DEV      = 8,
    localparam int FRAME_BITS = N_DEV * SUB_BITS,
    localparam int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                master_i,
    input  logic                fs_i,
    output logic                fs_o,
    input  logic [SMP_BITS-1:0] smp_l_i,
    input  logic [SMP_BITS-1:0] smp_r_i,
    input  logic                smp_vld_i,
    input  logic [1:0]          wl_i,
    input  logic                chain_i,
    output logic                sdo_o
);

    logic             start;
    logic [CNT_W-1:0] cnt;
    pair_t            in_pair;
    pair_t            hold_q;
    pair_t            act_q;
    wl_e              wl_q;
    logic             mux_bit;
    logic             dly_bit;
    logic             nxt_bit;

    assign in_pair = '{left: smp_l_i, right: smp_r_i};

    tdm_frame_timer #(
        .FRAME_BITS (FRAME_BITS)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .master_i (master_i),
        .fs_i     (fs_i),
        .start_o  (start),
        .cnt_o    (cnt),
        .fs_o     (fs_o)
    );

    // Sample pair holding register and per-frame snapshot.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            act_q  <= '0;
            wl_q   <= WL_24;
        end else begin
            if (smp_vld_i) begin
                hold_q <= in_pair;
            end
            if (start) begin
                act_q <= smp_vld_i ? in_pair : hold_q;
                wl_q  <= wl_e'(wl_i);
            end
        end
    end

    tdm_slot_mux u_mux (
        .pair_i (act_q),
        .wl_i   (wl_q),
        .pos_i  (cnt[OFF_W-1:0]),
        .bit_o  (mux_bit)
    );

    tdm_chain_delay #(
        .DEPTH (SUB_BITS)
    ) u_delay (
        .clk    (clk),
        .rst    (rst),
        .din_i  (chain_i),
        .dout_o (dly_bit)
    );

    assign nxt_bit = (int'(cnt) < SUB_BITS) ? mux_bit : dly_bit;

    always_ff @(negedge clk) begin
        if (rst) begin
            sdo_o <= 1'b0;
        end else begin
            sdo_o <= nxt_bit;
        end
    end

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((int'(cnt) < SUB_BITS) && (cnt[SLOT_W-1:0] >= wl_len(wl_q))) |-> !mux_bit); // R3

    AST_HOLD_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (start && !smp_vld_i) |=> act_q == $past(hold_q));         // R7

    AST_WL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(wl_q));                                  // R8

    AST_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt) >= SUB_BITS) |-> sdo_o == dly_bit);              // R4

endmodule

// File: tb/tdm_chain_tx_tb.sv
module tdm_chain_tx_tb;

    localparam int NDEV = 3;
    localparam int F    = NDEV * 64;
    localparam int NV   = 6;

    // {new, wl, left, right, chain word}
    localparam logic [82:0] VEC [NV] = '{
        {1'b1, 2'b00, 24'hA5C3F1, 24'h0F0F0F, 32'hDEADBEEF},
        {1'b1, 2'b01, 24'h7FFFFF, 24'h800001, 32'h12345678},
        {1'b1, 2'b10, 24'hFFFFFF, 24'hFFFFFF, 32'hFFFFFFFF},
        {1'b1, 2'b11, 24'h123456, 24'hFEDCBA, 32'h00000000},
        {1'b0, 2'b00, 24'h000000, 24'h000000, 32'hA0A0A0A0},
        {1'b1, 2'b00, 24'h800000, 24'h000001, 32'hC3C3C3C3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        master = 1'b0;
    logic        fs_in = 1'b0;
    logic        fs_out;
    logic [23:0] sl = '0;
    logic [23:0] sr = '0;
    logic        vld = 1'b0;
    logic [1:0]  wl = 2'b00;
    logic        sdi = 1'b0;
    logic        sdo;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [23:0] el = '0;
    logic [23:0] er = '0;

    always #5 clk = ~clk;

    tdm_chain_tx #(.N_DEV(NDEV)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .master_i  (master),
        .fs_i      (fs_in),
        .fs_o      (fs_out),
        .smp_l_i   (sl),
        .smp_r_i   (sr),
        .smp_vld_i (vld),
        .wl_i      (wl),
        .chain_i   (sdi),
        .sdo_o     (sdo)
    );

    task automatic chk(input bit ok, input string msg, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", msg, got, exp);
        end
    endtask

    function automatic int wlen(input logic [1:0] c);
        case (c)
            2'b00:   return 24;
            2'b01:   return 20;
            2'b10:   return 18;
            default: return 16;
        endcase
    endfunction

    function automatic logic cb(input logic [31:0] w, input int j);
        return w[31 - (j % 32)];
    endfunction

    function automatic logic [31:0] slot_exp(input logic [23:0] s, input int w);
        logic [31:0] r;
        r = '0;
        for (int b = 0; b < 32; b++) begin
            r[31-b] = (b < w) ? s[23-b] : 1'b0;
        end
        return r;
    endfunction

    task automatic run_frame(input logic new_s, input logic [1:0] wcode,
                             input logic [23:0] l, input logic [23:0] r,
                             input logic [31:0] cw, input int chg_k,
                             input logic [1:0] chg_wl, input string tag);
        logic [F-1:0] got;
        logic [31:0]  gl;
        logic [31:0]  gr;
        logic         a;
        int           edge_err;
        int           mism;
        int           w;
        edge_err = 0;
        mism     = 0;
        w        = wlen(wcode);
        @(posedge clk); #2;
        sl = l; sr = r; vld = new_s; wl = wcode;
        if (new_s) begin
            el = l;
            er = r;
        end
        @(posedge clk); #2;
        vld = 1'b0;
        fs_in = 1'b1;
        @(posedge clk); #2;
        sdi = cb(cw, 0);
        for (int k = 0; k < F; k++) begin
            @(negedge clk); #1;
            a = sdo;
            @(posedge clk); #1;
            got[k] = sdo;
            if (a !== sdo) edge_err++;
            #1;
            sdi = cb(cw, k + 1);
            if (k == 30) fs_in = 1'b0;
            if (k == chg_k) wl = chg_wl;
        end
        for (int b = 0; b < 32; b++) begin
            gl[31-b] = got[b];
            gr[31-b] = got[32+b];
        end
        for (int p = 64; p < F; p++) begin
            if (got[p] !== cb(cw, p - 64)) mism++;
        end
        chk(gl === slot_exp(el, w), $sformatf("%s/R2 left slot", tag), gl, slot_exp(el, w));
        chk(gr === slot_exp(er, w), $sformatf("%s/R2 right slot", tag), gr, slot_exp(er, w));
        chk(mism == 0, $sformatf("%s R4 forwarded bits mismatching", tag), mism, 0);
        chk(edge_err == 0, $sformatf("%s R5 output moved off falling edge", tag), edge_err, 0);
    endtask

    initial begin
        int errs;
        int highs;
        int rises;
        int first;
        int second;
        int msb_bad;
        logic prev;

        // R1: reset state
        repeat (5) @(posedge clk);
        chk(sdo === 1'b0 && fs_out === 1'b0, "R1 outputs during reset", {sdo, fs_out}, 0);
        #2 rst = 1'b0;
        errs = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk); #1;
            if (sdo !== 1'b0 || fs_out !== 1'b0) errs++;
        end
        chk(errs == 0, "R1 idle outputs after reset", errs, 0);

        // Vector table: R2, R3, R4, R5, R7
        for (int i = 0; i < NV; i++) begin
            run_frame(VEC[i][82], VEC[i][81:80], VEC[i][79:56], VEC[i][55:32],
                      VEC[i][31:0], -1, 2'b00, VEC[i][82] ? "R3" : "R7");
        end

        // R8: word length changed mid-frame applies only to the next frame
        run_frame(1'b1, 2'b00, 24'hFFFFFF, 24'hFFFFFF, 32'h5A5A5A5A, 10, 2'b11, "R8 mid-frame");
        run_frame(1'b0, 2'b11, 24'h0, 24'h0, 32'h0F0F0F0F, -1, 2'b11, "R8 next frame");

        // R6: master mode frame pulse, fs_i ignored
        @(posedge clk); #2;
        sl = 24'h800000; sr = 24'h0; vld = 1'b1;
        el = sl; er = sr;
        @(posedge clk); #2;
        vld = 1'b0;
        master = 1'b1;
        highs = 0; rises = 0; first = -1; second = -1; msb_bad = 0; prev = 1'b0;
        for (int c = 0; c < 2 * F; c++) begin
            @(negedge clk); #1;
            if (fs_out) highs++;
            if (fs_out && !prev) begin
                rises++;
                if (first < 0) first = c; else second = c;
                if (sdo !== 1'b1) msb_bad++;
            end
            prev = fs_out;
            @(posedge clk); #2;
            fs_in = (c % 3 == 0);
        end
        chk(highs == 64, "R6 frame pulse high count", highs, 64);
        chk(rises == 2, "R6 frame pulse rises", rises, 2);
        chk(second - first == F, "R6 frame period", second - first, F);
        chk(msb_bad == 0, "R6/R2 position 0 at pulse rise", msb_bad, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule